// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block is an atomic fetch-and-add engine that works on a small file of shared base registers. Each cycle, any number of requesting thread units may present a base index and an increment. The unit gathers all requests aimed at the same base and treats them as one multi-operand operation. Each requester gets back the base value plus the sum of the increments of the requesters ranked ahead of it, and the base advances by the sum of all of them. Requests are never serialized.

Requests to different bases proceed side by side in the same cycle. A master port sets and reads the base registers. A master write wins over requests presented in the same cycle: those requests are held and applied in the next cycle, on top of the written value. A typical use is compaction: every thread that owns a live element adds one, and the value it gets back is a unique output slot.

Top module: `psu_unit`

## Requirements
- R1: A lone request with increment L to base b returns the value base b held before the request, and base b becomes that value plus L.
- R2: Among requests to one base in the same cycle, ranking is by ascending requester index. Requester i receives the base value plus the sum of the increments of all lower-indexed requesters aimed at the same base in that cycle.
- R3: After a combined operation, the base holds its previous value plus the sum of every increment aimed at it in that cycle.
- R4: Requests to different bases in the same cycle do not interact. A base that no request targets and that is not written keeps its value.
- R5: A request accepted at a clock edge raises `rsp_valid_o` for that requester for one cycle after that edge. The base update takes effect at the same edge. With no accepted request, `rsp_valid_o` stays low.
- R6: All additions wrap modulo 2^DATA_W.
- R7: When `cfg_wr_i` is high, base `cfg_sel_i` takes `cfg_wdata_i` at the clock edge. `cfg_rdata_o` always shows the current value of base `cfg_sel_i`, with no register on the path.
- R8: Requests presented in a cycle with `cfg_wr_i` high produce no response at that edge. They are applied at the next edge against the written value, so their responses appear two cycles after issue. If the write is repeated, they keep waiting.
- R9: A requester whose request is waiting under R8 has any new request it presents in the retry cycle ignored. No extra response follows, and the new request does not change the base.
- R10: While reset is active, all base registers are zero and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request strobe per requester |
| req_base_i | input | N_REQ*BASE_W | Base index per requester, requester i at bits [i*BASE_W +: BASE_W] |
| req_inc_i | input | N_REQ*DATA_W | Increment per requester, requester i at bits [i*DATA_W +: DATA_W] |
| cfg_wr_i | input | 1 | Master write strobe |
| cfg_sel_i | input | BASE_W | Base selected for master write and read |
| cfg_wdata_i | input | DATA_W | Master write data |
| cfg_rdata_o | output | DATA_W | Current value of the selected base |
| rsp_valid_o | output | N_REQ | Response strobe per requester |
| rsp_value_o | output | N_REQ*DATA_W | Returned old-value share per requester, same packing as req_inc_i |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle response timing, and the absence of spurious responses;
- that a write blocks all responses at its edge;
- that an updated base equals its old value plus its scanned total, and that an untouched base stays stable;
- that requester 0 always receives the unmodified base.

Only the bench scenarios can show that each rank sees exactly the sum of the lower-indexed increments to its own base, across the following patterns:
- all requesters on one base (compaction);
- split and interleaved bases;
- sparse requesters;
- modulo wrap;
- the deferred retry after a write, including a repeated request from a waiting requester being dropped.

// File: rtl/psu_pkg.sv
`timescale 1ns/1ps
package psu_pkg;
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/psu_req_stage.sv
`timescale 1ns/1ps
// Holds requests deferred by a master write and merges them with new ones.
module psu_req_stage #(
  parameter int N_REQ  = 8,
  parameter int BASE_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hold_i,
  input  logic [N_REQ-1:0]         req_valid_i,
  input  logic [N_REQ*BASE_W-1:0]  req_base_i,
  input  logic [N_REQ*DATA_W-1:0]  req_inc_i,
  output logic [N_REQ-1:0]         pend_o,
  output logic [N_REQ-1:0]         eff_valid_o,
  output logic [N_REQ*BASE_W-1:0]  eff_base_o,
  output logic [N_REQ*DATA_W-1:0]  eff_inc_o
);
  logic [N_REQ-1:0]        pend_q;
  logic [N_REQ*BASE_W-1:0] pbase_q;
  logic [N_REQ*DATA_W-1:0] pinc_q;

  for (genvar i = 0; i < N_REQ; i++) begin : g_mux
    assign eff_base_o[i*BASE_W +: BASE_W] =
      pend_q[i] ? pbase_q[i*BASE_W +: BASE_W] : req_base_i[i*BASE_W +: BASE_W];
    assign eff_inc_o[i*DATA_W +: DATA_W] =
      pend_q[i] ? pinc_q[i*DATA_W +: DATA_W] : req_inc_i[i*DATA_W +: DATA_W];
  end
  assign eff_valid_o = pend_q | req_valid_i;
  assign pend_o      = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      pbase_q <= '0;
      pinc_q  <= '0;
    end else begin
      pend_q <= hold_i ? eff_valid_o : '0;
      if (hold_i) begin
        pbase_q <= eff_base_o;
        pinc_q  <= eff_inc_o;
      end
    end
  end
endmodule

// File: rtl/psu_scan.sv
`timescale 1ns/1ps
// Exclusive prefix of increments aimed at one base, in requester index order.
module psu_scan #(
  parameter int N_REQ   = 8,
  parameter int BASE_W  = 2,
  parameter int DATA_W  = 32,
  parameter int BASE_ID = 0
) (
  input  logic [N_REQ-1:0]         valid_i,
  input  logic [N_REQ*BASE_W-1:0]  base_i,
  input  logic [N_REQ*DATA_W-1:0]  inc_i,
  output logic [N_REQ*DATA_W-1:0]  excl_o,
  output logic [DATA_W-1:0]        total_o,
  output logic                     hit_o
);
  localparam logic [BASE_W-1:0] ID = BASE_W'(BASE_ID);

  always_comb begin
    logic [DATA_W-1:0] acc;
    acc   = '0;
    hit_o = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      excl_o[i*DATA_W +: DATA_W] = acc;
      if (valid_i[i] && base_i[i*BASE_W +: BASE_W] == ID) begin
        acc   = acc + inc_i[i*DATA_W +: DATA_W];
        hit_o = 1'b1;
      end
    end
    total_o = acc;
  end
endmodule

// File: rtl/psu_base_file.sv
`timescale 1ns/1ps
module psu_base_file #(
  parameter int N_BASE = 4,
  parameter int BASE_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BASE_W-1:0] sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_BASE-1:0] upd_en_i,
  input  logic [DATA_W-1:0] total_i [N_BASE],
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] base_o [N_BASE]
);
  logic [DATA_W-1:0] base_q [N_BASE];

  for (genvar b = 0; b < N_BASE; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 base_q[b] <= '0;
      else if (wr_i && sel_i == BASE_W'(b))        base_q[b] <= wdata_i;
      else if (upd_en_i[b])                        base_q[b] <= base_q[b] + total_i[b];
    end

    a_r3_base_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_en_i[b] && !wr_i) |=> base_q[b] == $past(base_q[b]) + $past(total_i[b]));
    a_r4_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_en_i[b] && !(wr_i && sel_i == BASE_W'(b))) |=> $stable(base_q[b]));
    a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sel_i == BASE_W'(b)) |=> base_q[b] == $past(wdata_i));
  end

  assign base_o  = base_q;
  assign rdata_o = base_q[sel_i];
endmodule

// File: rtl/psu_unit.sv
`timescale 1ns/1ps
module psu_unit #(
  parameter int N_REQ  = 8,
  parameter int N_BASE = 4,
  parameter int DATA_W = 32,
  localparam int BASE_W = psu_pkg::sel_width(N_BASE)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_REQ-1:0]         req_valid_i,
  input  logic [N_REQ*BASE_W-1:0]  req_base_i,
  input  logic [N_REQ*DATA_W-1:0]  req_inc_i,
  input  logic                     cfg_wr_i,
  input  logic [BASE_W-1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0]        cfg_wdata_i,
  output logic [DATA_W-1:0]        cfg_rdata_o,
  output logic [N_REQ-1:0]         rsp_valid_o,
  output logic [N_REQ*DATA_W-1:0]  rsp_value_o
);
  logic [N_REQ-1:0]        pend, eff_valid;
  logic [N_REQ*BASE_W-1:0] eff_base;
  logic [N_REQ*DATA_W-1:0] eff_inc;
  logic [N_REQ*DATA_W-1:0] excl [N_BASE];
  logic [DATA_W-1:0]       total [N_BASE];
  logic [DATA_W-1:0]       base_arr [N_BASE];
  logic [N_BASE-1:0]       hit, upd_en;
  logic [N_REQ*DATA_W-1:0] rsp_next;
  logic [N_REQ-1:0]        rsp_valid_q;
  logic [N_REQ*DATA_W-1:0] rsp_value_q;

  psu_req_stage #(.N_REQ(N_REQ), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_stage (
    .clk_i, .rst_ni, .hold_i(cfg_wr_i),
    .req_valid_i, .req_base_i, .req_inc_i,
    .pend_o(pend), .eff_valid_o(eff_valid), .eff_base_o(eff_base), .eff_inc_o(eff_inc)
  );

  for (genvar b = 0; b < N_BASE; b++) begin : g_scan
    psu_scan #(.N_REQ(N_REQ), .BASE_W(BASE_W), .DATA_W(DATA_W), .BASE_ID(b)) u_scan (
      .valid_i(eff_valid), .base_i(eff_base), .inc_i(eff_inc),
      .excl_o(excl[b]), .total_o(total[b]), .hit_o(hit[b])
    );
  end

  // a master write defers every request of the cycle
  assign upd_en = cfg_wr_i ? '0 : hit;

  psu_base_file #(.N_BASE(N_BASE), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_bases (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .upd_en_i(upd_en), .total_i(total), .rdata_o(cfg_rdata_o), .base_o(base_arr)
  );

  always_comb begin
    logic [BASE_W-1:0]       sel;
    logic [N_REQ*DATA_W-1:0] ex;
    for (int i = 0; i < N_REQ; i++) begin
      sel = eff_base[i*BASE_W +: BASE_W];
      ex  = excl[sel];
      rsp_next[i*DATA_W +: DATA_W] = base_arr[sel] + ex[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_value_q <= '0;
    end else begin
      rsp_valid_q <= cfg_wr_i ? '0 : eff_valid;
      for (int i = 0; i < N_REQ; i++)
        if (eff_valid[i] && !cfg_wr_i)
          rsp_value_q[i*DATA_W +: DATA_W] <= rsp_next[i*DATA_W +: DATA_W];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_value_o = rsp_value_q;

  logic [DATA_W-1:0] base_of_r0;
  assign base_of_r0 = base_arr[eff_base[BASE_W-1:0]];

  a_r2_rank0_gets_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_valid[0] && !cfg_wr_i) |=> rsp_value_o[DATA_W-1:0] == $past(base_of_r0));
  a_r8_write_blocks_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> rsp_valid_o == '0);

  for (genvar i = 0; i < N_REQ; i++) begin : g_chk
    a_r5_rsp_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[i] && !pend[i] && !cfg_wr_i) |=> rsp_valid_o[i]);
    a_r5_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_valid_i[i] && !pend[i]) |=> !rsp_valid_o[i]);
  end
endmodule

// File: tb/psu_unit_tb.sv
`timescale 1ns/1ps
module psu_unit_tb_top;
  localparam int N  = 8;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int BW = 2;
  localparam int NV = 6;

  // {valid[7:0], sel[15:0] two bits per requester, inc[63:0] one byte per requester}
  localparam logic [87:0] VEC [NV] = '{
    {8'hFF, 16'h0000, 64'h0101_0101_0101_0101},  // compaction on base 0
    {8'hFF, 16'hAA55, 64'h281E_140A_0403_0201},  // r0-3 base1, r4-7 base2
    {8'h81, 16'hC003, 64'h1100_0000_0000_007F},  // sparse, base3
    {8'h00, 16'h0000, 64'h0},                    // idle
    {8'h5A, 16'h2080, 64'h0008_0007_0600_0500},  // R4 interleaved bases 0/2
    {8'hFF, 16'hE4E4, 64'hFFFF_FFFF_FFFF_FFFF}   // all bases, two each
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*BW-1:0] req_base  = '0;
  logic [N*DW-1:0] req_inc   = '0;
  logic            cfg_wr    = 1'b0;
  logic [BW-1:0]   cfg_sel   = '0;
  logic [DW-1:0]   cfg_wdata = '0;
  logic [DW-1:0]   cfg_rdata;
  logic [N-1:0]    rsp_valid;
  logic [N*DW-1:0] rsp_value;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [DW-1:0] mb [NB];

  always #2.5 clk_i = ~clk_i;

  psu_unit dut_i (
    .clk_i, .rst_ni,
    .req_valid_i(req_valid), .req_base_i(req_base), .req_inc_i(req_inc),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .rsp_valid_o(rsp_valid), .rsp_value_o(rsp_value)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic readback(input string tag);
    for (int b = 0; b < NB; b++) begin
      cfg_sel = BW'(b);
      #0.1;
      check(cfg_rdata == mb[b], tag, cfg_rdata, mb[b]);
    end
  endtask

  task automatic run_req(input logic [N-1:0] v, input logic [2*N-1:0] s,
                         input logic [8*N-1:0] inc8, input string tv, input string tb);
    logic [DW-1:0] ev [N];
    for (int i = 0; i < N; i++) begin
      req_base[i*BW +: BW] = s[2*i +: 2];
      req_inc[i*DW +: DW]  = {24'h0, inc8[8*i +: 8]};
      ev[i] = '0;
      if (v[i]) begin
        ev[i] = mb[s[2*i +: 2]];
        mb[s[2*i +: 2]] = mb[s[2*i +: 2]] + {24'h0, inc8[8*i +: 8]};
      end
    end
    req_valid = v;
    @(posedge clk_i); #1;
    req_valid = '0;
    for (int i = 0; i < N; i++) begin
      check(rsp_valid[i] == v[i], "R5 valid", DW'(rsp_valid[i]), DW'(v[i]));
      if (v[i]) check(rsp_value[i*DW +: DW] == ev[i], tv, rsp_value[i*DW +: DW], ev[i]);
    end
    readback(tb);
  endtask

  task automatic master_write(input int b, input logic [DW-1:0] d);
    cfg_wr = 1'b1; cfg_sel = BW'(b); cfg_wdata = d;
    mb[b] = d;
    @(posedge clk_i); #1;
    cfg_wr = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) mb[b] = '0;
    #1;
    // R10 reset state
    check(rsp_valid == '0, "R10 rsp", DW'(rsp_valid), 0);
    readback("R10 bases");
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    for (int k = 0; k < NV; k++)
      run_req(VEC[k][87:80], VEC[k][79:64], VEC[k][63:0], "R2 rank share", "R3 R4 base");

    // R1 lone request
    run_req(8'h10, 16'h0000, 64'h0000_0009_0000_0000, "R1 old value", "R1 base");

    // R7 master write, other bases untouched
    master_write(3, 32'hDEAD_0000);
    check(rsp_valid == '0, "R7 no rsp", DW'(rsp_valid), 0);
    readback("R7 write/read");

    // R6 wrap
    master_write(2, 32'hFFFF_FFFF);
    run_req(8'h20, 16'h0800, 64'h0000_0300_0000_0000, "R6 old value", "R6 wrap base");

    // R8 write priority with deferred requests, R9 ignored repeat
    cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'd100;
    req_valid = 8'h05;
    req_base = '0; req_base[1:0] = 2'd1; req_base[5:4] = 2'd1;
    req_inc = '0; req_inc[0*DW +: DW] = 32'd5; req_inc[2*DW +: DW] = 32'd7;
    @(posedge clk_i); #1;
    check(rsp_valid == '0, "R8 blocked", DW'(rsp_valid), 0);
    cfg_wr = 1'b0;
    #0.1;
    check(cfg_rdata == 32'd100, "R8 written", cfg_rdata, 32'd100);
    req_valid = 8'h09;
    req_base[7:6] = 2'd1;
    req_inc[0*DW +: DW] = 32'd50; req_inc[2*DW +: DW] = 32'd0; req_inc[3*DW +: DW] = 32'd1;
    @(posedge clk_i); #1;
    req_valid = '0;
    check(rsp_valid == 8'h0D, "R8 R9 retry mask", DW'(rsp_valid), 32'h0D);
    check(rsp_value[0*DW +: DW] == 32'd100, "R8 r0", rsp_value[0*DW +: DW], 32'd100);
    check(rsp_value[2*DW +: DW] == 32'd105, "R8 r2", rsp_value[2*DW +: DW], 32'd105);
    check(rsp_value[3*DW +: DW] == 32'd112, "R8 r3", rsp_value[3*DW +: DW], 32'd112);
    mb[1] = 32'd113;
    readback("R9 base");
    @(posedge clk_i); #1;
    check(rsp_valid == '0, "R9 no extra rsp", DW'(rsp_valid), 0);
    readback("R9 base after");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule